// File: doc/BRIEF.md
# Five-Variable Euler-Step Chaos Generator

This block advances a coupled five-variable cubic polynomial map in signed fixed point, one forward-Euler step at a time. A 120-bit seed word loads all five state words at once. After that the block runs free. Every three clocks it writes a new state vector and marks it with a one-cycle valid strobe. Consumers such as keystream mixers or synchronisation loops take the five state words whenever the strobe is high.

Each step adds to every state a scaled drive polynomial. The polynomial has linear terms, pairwise state products and triple state products. Constant coefficients are built from shift-and-add networks. Only the state products use multipliers. Every product is computed at full width and rounded once. The drive is divided by 2^8 with rounding, and the sum is clamped to the 24-bit range.

Top module: `chaos5_stepper`

## Requirements
- R1: While reset is asserted, and after reset until the first seed load, all five state outputs read zero and the valid strobe is low.
- R2: A high `seed_load` at a rising edge copies `seed_in` into the states, with x=[119:96], y=[95:72], z=[71:48], w=[47:24] and v=[23:0]. Each state is a 24-bit two's-complement value with 18 fraction bits, so 0x040000 means 1.0. The strobe is high during the following cycle.
- R3: After a load, a new state vector appears every three clocks. The strobe is high for exactly one cycle per vector.
- R4: Pair products yz, xz and yy are rounded from their full-width products as (p + 2^17) >> 18. Triple products yzw, xzw, xyw and xyz are rounded as (p + 2^35) >> 36. Both shifts are arithmetic.
- R5: The drives, with >>1 an arithmetic shift, are:
  - Dx = 14y - (x>>1) + 2yz + yzw
  - Dy = 2x + 6y - xz - (4v + (v>>1)) - xzw
  - Dz = yy + xyw - 3z
  - Dw = (yz>>1) + xyz - 15w
- R6: Dv = s>>2 + s>>3 + s>>5 + s>>6 + s>>8, where s = x + v. Each shifted term is truncated separately.
- R7: The new state is the old state plus (D + 128) >> 8, clamped to the range 0x800000..0x7FFFFF.
- R8: A seed load takes effect in every sequencer phase, including the phase that would write a computed vector. The seed wins, and the cadence restarts from it.
- R9: With no seed loaded, the block stays idle and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_in | input | 120 | Packed five-state seed |
| seed_load | input | 1 | Load the seed at this edge |
| state_x | output | 24 | State x |
| state_y | output | 24 | State y |
| state_z | output | 24 | State z |
| state_w | output | 24 | State w |
| state_v | output | 24 | State v |
| state_valid | output | 1 | One-cycle strobe for a fresh state vector |

## Verification
A seed load and the write of a computed vector can fall on the same edge. The bench provokes this by raising the load two cycles after a strobe, which is exactly the edge where the write phase would land. The result is judged by the states in the next cycle: they must equal the new seed, not the computed step. The following strobes must come three cycles apart and follow the new seed bit for bit. An integer reference model predicts every vector over several hundred steps, plus runs at both clamp limits.

// File: rtl/chaos5_pkg.sv
package chaos5_pkg;
  localparam int unsigned LANES = 5;
  localparam int unsigned NPROD = 7;
  // lane indices
  localparam int unsigned LX = 0;
  localparam int unsigned LY = 1;
  localparam int unsigned LZ = 2;
  localparam int unsigned LW = 3;
  localparam int unsigned LV = 4;
  // product indices
  localparam int unsigned P_YZ  = 0;
  localparam int unsigned P_XZ  = 1;
  localparam int unsigned P_YY  = 2;
  localparam int unsigned P_YZW = 3;
  localparam int unsigned P_XZW = 4;
  localparam int unsigned P_XYW = 5;
  localparam int unsigned P_XYZ = 6;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SCALE = 2'd1,
    PH_SUM   = 2'd2,
    PH_WRITE = 2'd3
  } phase_t;
endpackage

// File: rtl/chaos5_products.sv
module chaos5_products
  import chaos5_pkg::*;
#(
  parameter int W  = 24,
  parameter int F  = 18,
  parameter int AW = 3 * W
) (
  input  logic signed [W-1:0]  st   [LANES],
  output logic signed [AW-1:0] prod [NPROD]
);
  localparam logic signed [AW-1:0] HALF1 = AW'(1) <<< (F - 1);
  localparam logic signed [AW-1:0] HALF2 = AW'(1) <<< (2 * F - 1);

  // round-half-up arithmetic right shift, done once from the full product
  function automatic logic signed [AW-1:0] rnd_pair(input logic signed [AW-1:0] p);
    return (p + HALF1) >>> F;
  endfunction

  function automatic logic signed [AW-1:0] rnd_triple(input logic signed [AW-1:0] p);
    return (p + HALF2) >>> (2 * F);
  endfunction

  logic signed [AW-1:0] f_yz, f_xz, f_yy, f_yzw, f_xzw, f_xyw, f_xyz;

  always_comb begin
    f_yz  = st[LY] * st[LZ];
    f_xz  = st[LX] * st[LZ];
    f_yy  = st[LY] * st[LY];
    f_yzw = st[LY] * st[LZ] * st[LW];
    f_xzw = st[LX] * st[LZ] * st[LW];
    f_xyw = st[LX] * st[LY] * st[LW];
    f_xyz = st[LX] * st[LY] * st[LZ];
    prod[P_YZ]  = rnd_pair(f_yz);
    prod[P_XZ]  = rnd_pair(f_xz);
    prod[P_YY]  = rnd_pair(f_yy);
    prod[P_YZW] = rnd_triple(f_yzw);
    prod[P_XZW] = rnd_triple(f_xzw);
    prod[P_XYW] = rnd_triple(f_xyw);
    prod[P_XYZ] = rnd_triple(f_xyz);
  end
endmodule

// File: rtl/chaos5_drive.sv
module chaos5_drive
  import chaos5_pkg::*;
#(
  parameter int W  = 24,
  parameter int AW = 3 * W
) (
  input  logic signed [W-1:0]  st   [LANES],
  input  logic signed [AW-1:0] prod [NPROD],
  output logic signed [AW-1:0] drv  [LANES]
);
  logic signed [AW-1:0] e [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_ext
    assign e[g] = {{(AW-W){st[g][W-1]}}, st[g]};
  end

  // k ~ 0.4258 as a five-term shift sum
  function automatic logic signed [AW-1:0] k_scale(input logic signed [AW-1:0] s);
    return (s >>> 2) + (s >>> 3) + (s >>> 5) + (s >>> 6) + (s >>> 8);
  endfunction

  always_comb begin
    // a=14, b=0.5, c=2
    drv[LX] = ((e[LY] <<< 4) - (e[LY] <<< 1)) - (e[LX] >>> 1)
            + (prod[P_YZ] <<< 1) + prod[P_YZW];
    // d=2, l=6, f=4.5
    drv[LY] = (e[LX] <<< 1) + (e[LY] <<< 2) + (e[LY] <<< 1) - prod[P_XZ]
            - ((e[LV] <<< 2) + (e[LV] >>> 1)) - prod[P_XZW];
    // h=3
    drv[LZ] = prod[P_YY] + prod[P_XYW] - ((e[LZ] <<< 1) + e[LZ]);
    // j=0.5, p=15
    drv[LW] = (prod[P_YZ] >>> 1) + prod[P_XYZ] - ((e[LW] <<< 4) - e[LW]);
    drv[LV] = k_scale(e[LX] + e[LV]);
  end
endmodule

// File: rtl/chaos5_step.sv
module chaos5_step
  import chaos5_pkg::*;
#(
  parameter int W    = 24,
  parameter int AW   = 3 * W,
  parameter int STEP = 8
) (
  input  logic signed [W-1:0]  st  [LANES],
  input  logic signed [AW-1:0] drv [LANES],
  output logic signed [AW-1:0] nxt [LANES]
);
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (STEP - 1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [AW-1:0] base;
    assign base   = {{(AW-W){st[g][W-1]}}, st[g]};
    assign nxt[g] = base + ((drv[g] + HALF) >>> STEP);
  end
endmodule

// File: rtl/chaos5_stepper.sv
module chaos5_stepper
  import chaos5_pkg::*;
#(
  parameter int W    = 24,
  parameter int F    = 18,
  parameter int STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5*W-1:0]    seed_in,
  input  logic              seed_load,
  output logic [W-1:0]      state_x,
  output logic [W-1:0]      state_y,
  output logic [W-1:0]      state_z,
  output logic [W-1:0]      state_w,
  output logic [W-1:0]      state_v,
  output logic              state_valid
);
  localparam int AW = 3 * W;
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (W - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (W - 1));

  phase_t phase;
  logic signed [W-1:0]  st     [LANES];
  logic signed [AW-1:0] prod_c [NPROD];
  logic signed [AW-1:0] prod_q [NPROD];
  logic signed [AW-1:0] drv    [LANES];
  logic signed [AW-1:0] nxt_c  [LANES];
  logic signed [AW-1:0] nxt_q  [LANES];
  logic signed [W-1:0]  sat_c  [LANES];

  // named events for the checker
  logic load_evt, idle_evt, write_evt;
  assign load_evt  = seed_load;
  assign idle_evt  = (phase == PH_IDLE);
  assign write_evt = (phase == PH_WRITE) && !seed_load;

  chaos5_products #(.W(W), .F(F), .AW(AW)) u_prod (
    .st(st), .prod(prod_c)
  );
  chaos5_drive #(.W(W), .AW(AW)) u_drive (
    .st(st), .prod(prod_q), .drv(drv)
  );
  chaos5_step #(.W(W), .AW(AW), .STEP(STEP)) u_step (
    .st(st), .drv(drv), .nxt(nxt_c)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_sat
    always_comb begin
      if (nxt_q[g] > MAXV)      sat_c[g] = MAXV[W-1:0];
      else if (nxt_q[g] < MINV) sat_c[g] = MINV[W-1:0];
      else                      sat_c[g] = nxt_q[g][W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      state_valid <= 1'b0;
      for (int i = 0; i < LANES; i++) begin
        st[i]    <= '0;
        nxt_q[i] <= '0;
      end
      for (int i = 0; i < NPROD; i++) prod_q[i] <= '0;
    end else if (seed_load) begin
      for (int i = 0; i < LANES; i++) st[i] <= seed_in[(LANES-1-i)*W +: W];
      state_valid <= 1'b1;
      phase       <= PH_SCALE;
    end else begin
      unique case (phase)
        PH_IDLE: state_valid <= 1'b0;
        PH_SCALE: begin
          for (int i = 0; i < NPROD; i++) prod_q[i] <= prod_c[i];
          state_valid <= 1'b0;
          phase       <= PH_SUM;
        end
        PH_SUM: begin
          for (int i = 0; i < LANES; i++) nxt_q[i] <= nxt_c[i];
          phase <= PH_WRITE;
        end
        PH_WRITE: begin
          for (int i = 0; i < LANES; i++) st[i] <= sat_c[i];
          state_valid <= 1'b1;
          phase       <= PH_SCALE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign state_x = st[LX];
  assign state_y = st[LY];
  assign state_z = st[LZ];
  assign state_w = st[LW];
  assign state_v = st[LV];
endmodule

// File: rtl/chaos5_stepper_chk.sv
module chaos5_stepper_chk #(
  parameter int W = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic [5*W-1:0] seed_in,
  input logic           load_evt,
  input logic           idle_evt,
  input logic           write_evt,
  input logic           state_valid,
  input logic [W-1:0]   state_x,
  input logic [W-1:0]   state_v
);
  logic [2:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap <= 3'd7;
    else if (state_valid) gap <= 3'd0;
    else if (gap != 3'd7) gap <= gap + 3'd1;
  end

  AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> state_valid); // R2
  AST_LOAD_X: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (state_x == $past(seed_in[5*W-1 -: W]))); // R2
  AST_LOAD_V: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (state_v == $past(seed_in[W-1:0]))); // R2
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_valid && !load_evt) |=> !state_valid); // R3
  AST_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_valid && !$past(load_evt)) |-> (gap == 3'd2)); // R3
  AST_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    write_evt |=> state_valid); // R3
  AST_SEED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (state_x == $past(seed_in[5*W-1 -: W]) && state_valid)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_evt && !load_evt) |=> !state_valid); // R9
endmodule

bind chaos5_stepper chaos5_stepper_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_in(seed_in), .load_evt(load_evt),
  .idle_evt(idle_evt), .write_evt(write_evt), .state_valid(state_valid),
  .state_x(state_x), .state_v(state_v)
);

// File: tb/chaos5_stepper_bench.sv
module chaos5_stepper_bench;
  localparam int CLK_NS = 10;
  localparam int W = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [5*W-1:0] seed_in = '0;
  logic           seed_load = 1'b0;
  logic [W-1:0]   state_x, state_y, state_z, state_w, state_v;
  logic           state_valid;

  int total = 0;
  int bad = 0;

  chaos5_stepper u_chaos5_stepper (
    .clk(clk), .rst_n(rst_n), .seed_in(seed_in), .seed_load(seed_load),
    .state_x(state_x), .state_y(state_y), .state_z(state_z),
    .state_w(state_w), .state_v(state_v), .state_valid(state_valid)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef logic signed [127:0] big_t;
  big_t m [5];

  function automatic big_t ext(input logic [23:0] f);
    return {{104{f[23]}}, f};
  endfunction

  function automatic big_t rnd(input big_t p, input int sh);
    return (p + (big_t'(1) <<< (sh - 1))) >>> sh;
  endfunction

  function automatic big_t clampv(input big_t v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic logic [119:0] dut_vec();
    return {state_x, state_y, state_z, state_w, state_v};
  endfunction

  function automatic logic [119:0] model_vec();
    return {m[0][23:0], m[1][23:0], m[2][23:0], m[3][23:0], m[4][23:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [119:0] act,
                       input logic [119:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4 R5 R6 R7: one Euler step of the reference model, constants as multiplies
  task automatic model_step();
    big_t x, y, z, w, v, yz, xz, yy, yzw, xzw, xyw, xyz, s;
    big_t d [5];
    x = m[0]; y = m[1]; z = m[2]; w = m[3]; v = m[4];
    yz  = rnd(y * z, 18);
    xz  = rnd(x * z, 18);
    yy  = rnd(y * y, 18);
    yzw = rnd(y * z * w, 36);
    xzw = rnd(x * z * w, 36);
    xyw = rnd(x * y * w, 36);
    xyz = rnd(x * y * z, 36);
    s = x + v;
    d[0] = 14 * y - (x >>> 1) + 2 * yz + yzw;
    d[1] = 2 * x + 6 * y - xz - (4 * v + (v >>> 1)) - xzw;
    d[2] = yy + xyw - 3 * z;
    d[3] = (yz >>> 1) + xyz - 15 * w;
    d[4] = (s >>> 2) + (s >>> 3) + (s >>> 5) + (s >>> 6) + (s >>> 8);
    for (int i = 0; i < 5; i++) m[i] = clampv(m[i] + rnd(d[i], 8));
  endtask

  task automatic load_seed(input logic [119:0] k);
    @(negedge clk);
    seed_in = k;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    check(state_valid === 1'b1, "R2 strobe after load", {119'd0, state_valid}, 120'd1);
    check(dut_vec() === k, "R2 seed unpack", dut_vec(), k);
    m[0] = ext(k[119:96]); m[1] = ext(k[95:72]); m[2] = ext(k[71:48]);
    m[3] = ext(k[47:24]);  m[4] = ext(k[23:0]);
  endtask

  task automatic step_check(input string req);
    int gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!state_valid && gap < 8);
    check(gap == 3, "R3 cadence", 120'(gap), 120'd3);
    model_step();
    check(dut_vec() === model_vec(), req, dut_vec(), model_vec());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(state_valid === 1'b0 && dut_vec() === '0, "R1 reset",
          {dut_vec()[118:0], state_valid}, 120'd0);
    rst_n = 1'b1;
    // R9: idle without a seed
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(state_valid === 1'b0 && dut_vec() === '0, "R9 idle",
            {dut_vec()[118:0], state_valid}, 120'd0);
    end
    // R4 R5 R6 R7: long run from the reference seed
    load_seed(120'h040000_010000_080000_FCFFFF_060000);
    for (int i = 0; i < 300; i++) step_check("R5 R6 trajectory");
    // R8: seed load lands on the write edge
    @(negedge clk);
    @(negedge clk);
    seed_in = 120'h020000_FF0000_010000_008000_FE8000;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    check(state_valid === 1'b1 && dut_vec() === seed_in, "R8 seed beats write",
          dut_vec(), seed_in);
    m[0] = ext(seed_in[119:96]); m[1] = ext(seed_in[95:72]); m[2] = ext(seed_in[71:48]);
    m[3] = ext(seed_in[47:24]);  m[4] = ext(seed_in[23:0]);
    for (int i = 0; i < 100; i++) step_check("R8 R4 after reseed");
    // R7: clamp at both limits
    load_seed({5{24'h7FFFFF}});
    step_check("R7 upper clamp");
    check(state_z === 24'h7FFFFF, "R7 z at max", {96'd0, state_z}, {96'd0, 24'h7FFFFF});
    for (int i = 0; i < 20; i++) step_check("R7 run from max");
    load_seed({5{24'h800000}});
    step_check("R7 lower clamp");
    check(state_z === 24'h800000, "R7 z at min", {96'd0, state_z}, {96'd0, 24'h800000});
    for (int i = 0; i < 20; i++) step_check("R7 run from min");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule